// File: doc/BRIEF.md
# 64-bit Timestamp Counter with Snapshot and Preload

This block keeps a 64-bit count that advances on an input tick and wraps modulo 2^64. Software reaches it through a small synchronous 32-bit register bus with an address, a write enable, write data and a combinational read-data return.

Because a 64-bit value cannot be read in one 32-bit access, software first writes a command to the control register. The command copies the whole live count, in one cycle, into a snapshot register pair. The two halves can then be read at leisure and always form one consistent value.

A second command pattern on the same control register replaces the live count with a value staged in a load register pair. The control register also holds a prescaler field. Its zero setting passes every tick straight to the counter.

Top module: `tstamp_counter64`

## Requirements
- R1: After reset, every register reads as zero: control, both live halves, both load halves and both snapshot halves.
- R2: A write to control (byte address 0x68) with bit 0 = 1 and bit 1 = 0 copies the live count as it stood before that clock edge into the snapshot pair. The low half is at 0x7C and the high half at 0x80.
- R3: A write to control with bits 1:0 = 2'b11 sets the live count to {load high (0x78), load low (0x74)} on the next cycle. Counting resumes from that value, and a tick in the same cycle is discarded.
- R4: The live count wraps from 2^64-1 to 0, and a carry out of the low 32 bits advances the high 32 bits in the same step.
- R5: The snapshot pair keeps its value until the next snapshot command, however the live count moves in between.
- R6: With the divider field at zero, the live count (low half at 0x6C, high half at 0x70) goes up by exactly one in every cycle where tick is high and no load is commanded.
- R7: In a cycle with tick low and no load command, the live count does not change.
- R8: Control reads back the divider field in bits 7:4, and all other bits, including the command bits 1:0, read as 0. Every control write stores bits 7:4. A control write with bits 1:0 = 2'b10 or 2'b00 changes neither the live count nor the snapshot.
- R9: With divider value N, the count advances once per N+1 ticks. A load restarts the prescale phase, so the first advance after a load comes on the (N+1)th tick.
- R10: The load registers read back the value written to them. Writes to the live and snapshot addresses are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable tick |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume that the bus carries at most one access per cycle and that a command and a write to the load pair never arrive together. Since there is only one address, the second can never happen. They also assume that tick is a plain level sampled at the clock edge. The stimulus drives one access per cycle, changes every input only on the falling edge, and mixes directed command sequences with random accesses drawn only from the mapped addresses, with the divider kept small.

// File: rtl/tstamp_counter64.sv
`timescale 1ns/1ps
module tstamp_counter64 #(
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 4,
  parameter int DIV_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int CNT_W = 64;
  localparam int HALF  = CNT_W / 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h68);
  localparam logic [ADDR_W-1:0] A_LVLO = ADDR_W'(8'h6C);
  localparam logic [ADDR_W-1:0] A_LVHI = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] A_LDLO = ADDR_W'(8'h74);
  localparam logic [ADDR_W-1:0] A_LDHI = ADDR_W'(8'h78);
  localparam logic [ADDR_W-1:0] A_SNLO = ADDR_W'(8'h7C);
  localparam logic [ADDR_W-1:0] A_SNHI = ADDR_W'(8'h80);

  logic [CNT_W-1:0] cnt, snap, ld;
  logic [DIV_W-1:0] div, pre;

  wire ctrl_wr = bus_we && (bus_addr == A_CTRL);
  wire do_snap = ctrl_wr && (bus_wdata[1:0] == 2'b01);
  wire do_load = ctrl_wr && (bus_wdata[1:0] == 2'b11);
  wire step    = tick && (pre >= div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
      ld   <= '0;
      div  <= '0;
      pre  <= '0;
    end else begin
      if (do_snap) snap <= cnt;
      if (ctrl_wr) div <= bus_wdata[DIV_LSB +: DIV_W];
      if (bus_we && bus_addr == A_LDLO) ld[HALF-1:0] <= bus_wdata;
      if (bus_we && bus_addr == A_LDHI) ld[CNT_W-1:HALF] <= bus_wdata;
      if (do_load) begin
        cnt <= ld;
        pre <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        pre <= '0;
      end else if (tick) begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[DIV_LSB +: DIV_W] = div;
      A_LVLO: bus_rdata = cnt[HALF-1:0];
      A_LVHI: bus_rdata = cnt[CNT_W-1:HALF];
      A_LDLO: bus_rdata = ld[HALF-1:0];
      A_LDHI: bus_rdata = ld[CNT_W-1:HALF];
      A_SNLO: bus_rdata = snap[HALF-1:0];
      A_SNHI: bus_rdata = snap[CNT_W-1:HALF];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tstamp_counter64_chk.sv
`timescale 1ns/1ps
module tstamp_counter64_chk #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       cnt,
  input logic [63:0]       snap,
  input logic [63:0]       ld,
  input logic [DIV_W-1:0]  div
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h68);
  wire cw = bus_we && (bus_addr == A_CTRL);

  p_snap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_wdata[1:0] == 2'b01) |=> (snap == $past(cnt)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_wdata[1:0] == 2'b11) |=> (cnt == $past(ld)));

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw && bus_wdata[1:0] == 2'b01) |=> $stable(snap));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div == '0 && !(cw && bus_wdata[1:0] == 2'b11)) |=> (cnt == $past(cnt) + 64'd1));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(cw && bus_wdata[1:0] == 2'b11)) |=> $stable(cnt));

  p_ctrl_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[1:0] == 2'b00));
endmodule

bind tstamp_counter64 tstamp_counter64_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .snap(snap),
  .ld(ld), .div(div)
);

// File: tb/tstamp_counter64_tb.sv
`timescale 1ns/1ps
module tstamp_counter64_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint unsigned m_cnt = 0, m_snap = 0, m_ld = 0;
  int m_div = 0, m_pre = 0;

  always #2.5 clk = ~clk;

  tstamp_counter64 u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h68: mread = 32'(m_div) << 4;
      8'h6C: mread = m_cnt[31:0];
      8'h70: mread = m_cnt[63:32];
      8'h74: mread = m_ld[31:0];
      8'h78: mread = m_ld[63:32];
      8'h7C: mread = m_snap[31:0];
      8'h80: mread = m_snap[63:32];
      default: mread = 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d,
                     input logic tk, input string tag);
    int od;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; tick = tk;
    #1;
    checks++;
    if (bus_rdata !== mread(a)) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, mread(a));
    end
    @(posedge clk);
    if (rst_n) begin
      od = m_div;
      if (we && a == 8'h68 && d[1:0] == 2'b01) m_snap = m_cnt;
      if (we && a == 8'h74) m_ld[31:0] = d;
      if (we && a == 8'h78) m_ld[63:32] = d;
      if (we && a == 8'h68 && d[1:0] == 2'b11) begin
        m_cnt = m_ld; m_pre = 0;
      end else if (tk) begin
        if (m_pre >= od) begin m_cnt = m_cnt + 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
      if (we && a == 8'h68) m_div = int'(d[7:4]);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(a, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(a, 1'b1, d, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(8'h6C, 1'b0, 32'h0, 1'b1, tag);
  endtask

  task automatic load64(input longint unsigned v, input string tag);
    wr(8'h74, v[31:0], tag);
    wr(8'h78, v[63:32], tag);
    wr(8'h68, 32'(m_div) << 4 | 32'h3, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] amap [7];
    amap = '{8'h68, 8'h6C, 8'h70, 8'h74, 8'h78, 8'h7C, 8'h80};
    for (int i = 0; i < 7; i++) rd(amap[i], "R1 reset value");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 7; i++) rd(amap[i], "R1 after reset");

    ticks(5, "R6 every tick");
    rd(8'h6C, "R6 count after ticks");
    for (int i = 0; i < 4; i++) rd(8'h6C, "R7 no tick hold");

    wr(8'h74, 32'hDEAD_0010, "R10 load low write");
    wr(8'h78, 32'h0000_0007, "R10 load high write");
    rd(8'h74, "R10 load low readback");
    rd(8'h78, "R10 load high readback");
    cyc(8'h68, 1'b1, 32'h3, 1'b1, "R3 load with tick");
    rd(8'h70, "R3 live high");
    rd(8'h6C, "R3 live low");
    ticks(3, "R3 continue from load");

    wr(8'h68, 32'h1, "R2 snapshot command");
    rd(8'h80, "R2 snapshot high");
    rd(8'h7C, "R2 snapshot low");
    ticks(20, "R5 count moves");
    rd(8'h80, "R5 snapshot high held");
    rd(8'h7C, "R5 snapshot low held");

    wr(8'h68, 32'h2, "R8 bit1-only write");
    rd(8'h68, "R8 control readback");
    rd(8'h6C, "R8 count unchanged");
    rd(8'h7C, "R8 snapshot unchanged");
    wr(8'h68, 32'hFFFF_FF02, "R8 field write");
    rd(8'h68, "R8 only divider reads back");
    wr(8'h68, 32'h0, "R8 clear divider");

    load64(64'hFFFF_FFFF_FFFF_FFFE, "R4 load near top");
    ticks(1, "R4 below wrap");
    rd(8'h70, "R4 high at top");
    ticks(2, "R4 wrap");
    rd(8'h70, "R4 high after wrap");
    rd(8'h6C, "R4 low after wrap");
    load64(64'h0000_0000_FFFF_FFFF, "R4 carry setup");
    ticks(1, "R4 carry");
    rd(8'h70, "R4 carry into high");

    wr(8'h68, 32'h20, "R9 divider 2");
    rd(8'h68, "R9 divider readback");
    ticks(7, "R9 divided count");
    cyc(8'h6C, 1'b0, 32'h0, 1'b0, "R9 gap");
    ticks(2, "R9 divided count");
    load64(64'h0000_0001_0000_0000, "R9 load restarts phase");
    ticks(3, "R9 first step after load");
    rd(8'h6C, "R9 count after load");
    wr(8'h68, 32'h0, "R9 divider back to 0");

    rd(8'h00, "R10 unmapped read");
    rd(8'h84, "R10 unmapped read");
    wr(8'h6C, 32'h1234_5678, "R10 live write ignored");
    rd(8'h6C, "R10 live write ignored");
    wr(8'h80, 32'h1234_5678, "R10 snapshot write ignored");
    rd(8'h80, "R10 snapshot write ignored");

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] d;
      k = $urandom_range(0, 6);
      d = $urandom;
      if (k == 0) d = (d & 32'h0000_0013);
      cyc(amap[k], ($urandom_range(0, 3) == 0), d, $urandom_range(0, 1) == 1, "R6 random mix");
    end
    finish_run();
  end
endmodule